// File: doc/BRIEF.md
# Multi-Granular Directory Set

This block is a single set of a coherence directory cache. Each of its ways holds a sharer vector with one bit per core. A way can be a region entry, which covers every block of a 16-block aligned region. It can instead be a line entry, which covers one block only. The set index is taken from the region address, so a region entry and all of its per-block exceptions land in the same set. A lookup can therefore see both kinds of entry at once, and a matching line entry takes precedence over the region entry.

The surrounding controller selects the set and issues one request per cycle. A request is a lookup, a region allocation, a line-exception allocation or a sharer update. One cycle later the set answers with:
- a hit flag,
- a grain flag, which says whether a line entry supplied the answer,
- the sharer vector that now applies to the block,
- an eviction report when an allocation displaced a valid way.

When a line entry's vector becomes equal to its region's vector, the line entry is no longer an exception and is released.

Top module: `mgDirSet`

## Requirements
- R1: A request with reqValid high produces rspValid high exactly one clock later. A lookup that matches no entry answers rspHit=0, rspLineGrain=0 and rspSharers=0.
- R2: reqAddr is split as follows: bits [5:0] are the byte offset, bits [9:6] are the block within the region, bits [16:10] are the set index (ignored inside the set), and bits [31:17] are the region tag. A region entry matches any block whose tag is equal. A line entry matches only when both the tag and the block field are equal.
- R3: When a lookup matches both a line entry and a region entry, the response reports rspLineGrain=1 and the line entry's sharers.
- R4: An allocation that needs a new way takes the lowest-numbered invalid way and raises no eviction report.
- R5: When all ways are valid, an allocation replaces the way chosen by a round-robin pointer. The pointer starts at way 0 after reset and advances by one after each eviction. The response raises evictValid with the displaced entry's tag, its block field (0 for a region entry) and its grain (evictLineGrain=1 for a line entry).
- R6: Evicting a region entry also invalidates every line entry in the set that carries the same tag.
- R7: An update that matches a line entry rewrites that line entry when the new vector differs from the region's vector. An update that matches only a region entry rewrites the region entry. In both cases the response reports a hit and the new vector, with rspLineGrain showing which grain was written.
- R8: An update or line allocation that hits a line entry with a vector equal to its region entry's vector frees the line entry. The response reports rspHit=1, rspLineGrain=0 and that vector, and later lookups of the block resolve to the region entry.
- R9: An update that matches no entry changes no state and answers rspHit=0 with rspSharers=0.
- R10: Allocating an entry that already exists at the same grain rewrites it in place. The response reports rspHit=1 and raises no eviction report.
- R11: A line allocation whose vector equals the existing region entry's vector creates no entry. It answers rspHit=0, rspLineGrain=0 and the region's vector.
- R12: Reset invalidates every way, clears the round-robin pointer and holds rspValid and evictValid low.
- R13: reqOp is encoded as 0 for lookup, 1 for allocate region, 2 for allocate line and 3 for update. With reqValid low the set changes no state and rspValid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | Request kind (see R13) |
| reqAddr | input | 32 | Block address (see R2) |
| reqSharers | input | 16 | Sharer vector for allocations and updates |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspHit | output | 1 | A matching entry existed |
| rspLineGrain | output | 1 | The answer came from, or was written to, a line entry |
| rspSharers | output | 16 | Sharer vector that applies to the block |
| evictValid | output | 1 | An allocation displaced a valid way |
| evictTag | output | 15 | Region tag of the displaced entry |
| evictBlk | output | 4 | Block field of the displaced entry |
| evictLineGrain | output | 1 | The displaced entry was a line entry |

## Verification
The hardest situation to reach is a full set in which the round-robin victim is a region entry that still owns line exceptions in other ways. Only this case exercises the invalidation of those lines together with the eviction report. The stimulus first fills all eight ways with a mix of regions and lines. It then steers the pointer through a sequence of forced evictions, so that it reaches a region entry with live exceptions. Lookups of the invalidated blocks follow, to show that the exceptions are gone. Freeing a line by an update equal to its region is a second hard case, because it only shows at the ports. The stimulus checks it by looking the block up again and by refilling the freed way without any eviction.

// File: rtl/mgdir_pkg.sv
package mgdir_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP       = 2'd0,
    OP_ALLOC_REGION = 2'd1,
    OP_ALLOC_LINE   = 2'd2,
    OP_UPDATE       = 2'd3
  } dirOp_e;

  // strobes from control to datapath, all acting on the selected target way
  typedef struct packed {
    logic wrEn;         // write a fresh entry into the target way
    logic wrLineGrain;  // grain of the written entry (1 = line)
    logic killLines;    // drop other line entries sharing the target's old tag
    logic freeEn;       // invalidate the target way
  } dirStrobe_t;

endpackage

// File: rtl/mgDirDatapath.sv
module mgDirDatapath
  import mgdir_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int SHR_W    = 16,
  parameter int TAG_W    = 15,
  parameter int BLK_W    = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TAG_W-1:0]    reqTag,
  input  logic [BLK_W-1:0]    reqBlk,
  input  dirStrobe_t          strobe,
  input  logic [WAY_W-1:0]    tgtWay,
  input  logic [SHR_W-1:0]    wrShr,
  output logic [NUM_WAYS-1:0] validVec,
  output logic [NUM_WAYS-1:0] grainVec,
  output logic [NUM_WAYS-1:0] lineHitVec,
  output logic [NUM_WAYS-1:0] regionHitVec,
  output logic [SHR_W-1:0]    lineShr,
  output logic [SHR_W-1:0]    regionShr,
  output logic [TAG_W-1:0]    tgtTag,
  output logic [BLK_W-1:0]    tgtBlk
);

  logic [TAG_W-1:0] tagArr [NUM_WAYS];
  logic [BLK_W-1:0] blkArr [NUM_WAYS];
  logic [SHR_W-1:0] shrArr [NUM_WAYS];
  logic [NUM_WAYS-1:0] killVec;

  // per-way compare and kill qualification
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic tagEq;
    assign tagEq           = validVec[w] && (tagArr[w] == reqTag);
    assign regionHitVec[w] = tagEq && !grainVec[w];
    assign lineHitVec[w]   = tagEq && grainVec[w] && (blkArr[w] == reqBlk);
    assign killVec[w]      = strobe.killLines && (WAY_W'(w) != tgtWay) &&
                             validVec[w] && grainVec[w] && (tagArr[w] == tgtTag);
  end

  // sharer muxes: hit vectors are at most one-hot per grain
  always_comb begin
    lineShr   = '0;
    regionShr = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (lineHitVec[w])   lineShr   = lineShr   | shrArr[w];
      if (regionHitVec[w]) regionShr = regionShr | shrArr[w];
    end
  end

  assign tgtTag = tagArr[tgtWay];
  assign tgtBlk = blkArr[tgtWay];

  always_ff @(posedge clk) begin
    if (rst) begin
      validVec <= '0;
      grainVec <= '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        tagArr[w] <= '0;
        blkArr[w] <= '0;
        shrArr[w] <= '0;
      end
    end else begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (killVec[w]) validVec[w] <= 1'b0;
      end
      if (strobe.freeEn) validVec[tgtWay] <= 1'b0;
      if (strobe.wrEn) begin
        validVec[tgtWay] <= 1'b1;
        grainVec[tgtWay] <= strobe.wrLineGrain;
        tagArr[tgtWay]   <= reqTag;
        blkArr[tgtWay]   <= strobe.wrLineGrain ? reqBlk : '0;
        shrArr[tgtWay]   <= wrShr;
      end
    end
  end

endmodule

// File: rtl/mgDirControl.sv
module mgDirControl
  import mgdir_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int SHR_W    = 16,
  parameter int TAG_W    = 15,
  parameter int BLK_W    = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reqValid,
  input  logic [1:0]          reqOp,
  input  logic [SHR_W-1:0]    reqShr,
  input  logic [NUM_WAYS-1:0] validVec,
  input  logic [NUM_WAYS-1:0] grainVec,
  input  logic [NUM_WAYS-1:0] lineHitVec,
  input  logic [NUM_WAYS-1:0] regionHitVec,
  input  logic [SHR_W-1:0]    lineShr,
  input  logic [SHR_W-1:0]    regionShr,
  input  logic [TAG_W-1:0]    tgtTag,
  input  logic [BLK_W-1:0]    tgtBlk,
  output dirStrobe_t          strobe,
  output logic [WAY_W-1:0]    tgtWay,
  output logic                rspValid,
  output logic                rspHit,
  output logic                rspLineGrain,
  output logic [SHR_W-1:0]    rspSharers,
  output logic                evictValid,
  output logic [TAG_W-1:0]    evictTag,
  output logic [BLK_W-1:0]    evictBlk,
  output logic                evictLineGrain
);

  dirOp_e           op;
  logic [WAY_W-1:0] rrPtr, lineWay, regionWay, freeWay, victimWay;
  logic             anyLine, anyRegion, haveFree, eqRegion;
  logic             nxtHit, nxtLine, nxtEvict, advanceRr;
  logic [SHR_W-1:0] nxtShr;

  assign op        = dirOp_e'(reqOp);
  assign anyLine   = |lineHitVec;
  assign anyRegion = |regionHitVec;
  assign haveFree  = ~&validVec;
  assign eqRegion  = anyRegion && (reqShr == regionShr);
  assign victimWay = haveFree ? freeWay : rrPtr;

  // lowest-index encoders
  always_comb begin
    lineWay   = '0;
    regionWay = '0;
    freeWay   = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (lineHitVec[w])   lineWay   = WAY_W'(w);
      if (regionHitVec[w]) regionWay = WAY_W'(w);
      if (!validVec[w])    freeWay   = WAY_W'(w);
    end
  end

  always_comb begin
    strobe    = '0;
    tgtWay    = victimWay;
    nxtHit    = 1'b0;
    nxtLine   = 1'b0;
    nxtShr    = '0;
    nxtEvict  = 1'b0;
    advanceRr = 1'b0;
    if (reqValid) begin
      case (op)
        OP_LOOKUP: begin
          nxtHit  = anyLine || anyRegion;
          nxtLine = anyLine;
          nxtShr  = anyLine ? lineShr : (anyRegion ? regionShr : '0);
        end
        OP_ALLOC_REGION: begin
          nxtShr      = reqShr;
          strobe.wrEn = 1'b1;
          if (anyRegion) begin
            tgtWay = regionWay;
            nxtHit = 1'b1;
          end else begin
            strobe.killLines = validVec[victimWay] && !grainVec[victimWay];
            nxtEvict         = validVec[victimWay];
            advanceRr        = !haveFree;
          end
        end
        OP_ALLOC_LINE, OP_UPDATE: begin
          if (anyLine) begin
            tgtWay = lineWay;
            nxtHit = 1'b1;
            nxtShr = reqShr;
            if (eqRegion) begin
              strobe.freeEn = 1'b1;
            end else begin
              strobe.wrEn        = 1'b1;
              strobe.wrLineGrain = 1'b1;
              nxtLine            = 1'b1;
            end
          end else if (op == OP_ALLOC_LINE) begin
            if (eqRegion) begin
              nxtShr = regionShr;
            end else begin
              strobe.wrEn        = 1'b1;
              strobe.wrLineGrain = 1'b1;
              strobe.killLines   = validVec[victimWay] && !grainVec[victimWay];
              nxtEvict           = validVec[victimWay];
              advanceRr          = !haveFree;
              nxtLine            = 1'b1;
              nxtShr             = reqShr;
            end
          end else if (anyRegion) begin
            tgtWay      = regionWay;
            strobe.wrEn = 1'b1;
            nxtHit      = 1'b1;
            nxtShr      = reqShr;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrPtr          <= '0;
      rspValid       <= 1'b0;
      rspHit         <= 1'b0;
      rspLineGrain   <= 1'b0;
      rspSharers     <= '0;
      evictValid     <= 1'b0;
      evictTag       <= '0;
      evictBlk       <= '0;
      evictLineGrain <= 1'b0;
    end else begin
      if (advanceRr) begin
        rrPtr <= (rrPtr == WAY_W'(NUM_WAYS - 1)) ? '0 : rrPtr + 1'b1;
      end
      rspValid       <= reqValid;
      rspHit         <= nxtHit;
      rspLineGrain   <= nxtLine;
      rspSharers     <= nxtShr;
      evictValid     <= nxtEvict;
      evictTag       <= nxtEvict ? tgtTag : '0;
      evictBlk       <= nxtEvict ? tgtBlk : '0;
      evictLineGrain <= nxtEvict && grainVec[victimWay];
    end
  end

endmodule

// File: rtl/mgDirSet.sv
module mgDirSet
  import mgdir_pkg::*;
#(
  parameter int NUM_WAYS      = 8,
  parameter int NUM_CORES     = 16,
  parameter int ADDR_W        = 32,
  parameter int OFFSET_W      = 6,
  parameter int REGION_BLOCKS = 16,
  parameter int SET_W         = 7,
  localparam int BLK_W        = $clog2(REGION_BLOCKS),
  localparam int TAG_LSB      = OFFSET_W + BLK_W + SET_W,
  localparam int TAG_W        = ADDR_W - TAG_LSB,
  localparam int WAY_W        = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic [1:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_CORES-1:0] reqSharers,
  output logic                 rspValid,
  output logic                 rspHit,
  output logic                 rspLineGrain,
  output logic [NUM_CORES-1:0] rspSharers,
  output logic                 evictValid,
  output logic [TAG_W-1:0]     evictTag,
  output logic [BLK_W-1:0]     evictBlk,
  output logic                 evictLineGrain
);

  logic [TAG_W-1:0]    reqTag;
  logic [BLK_W-1:0]    reqBlk;
  logic                unusedAddrBits;
  dirStrobe_t          strobe;
  logic [WAY_W-1:0]    tgtWay;
  logic [NUM_WAYS-1:0] validVec, grainVec, lineHitVec, regionHitVec;
  logic [NUM_CORES-1:0] lineShr, regionShr;
  logic [TAG_W-1:0]    tgtTag;
  logic [BLK_W-1:0]    tgtBlk;

  assign reqTag         = reqAddr[ADDR_W-1:TAG_LSB];
  assign reqBlk         = reqAddr[OFFSET_W+BLK_W-1:OFFSET_W];
  assign unusedAddrBits = ^{reqAddr[TAG_LSB-1:OFFSET_W+BLK_W], reqAddr[OFFSET_W-1:0]};

  mgDirDatapath #(
    .NUM_WAYS(NUM_WAYS), .SHR_W(NUM_CORES), .TAG_W(TAG_W), .BLK_W(BLK_W)
  ) dp_i (
    .clk(clk), .rst(rst), .reqTag(reqTag), .reqBlk(reqBlk),
    .strobe(strobe), .tgtWay(tgtWay), .wrShr(reqSharers),
    .validVec(validVec), .grainVec(grainVec),
    .lineHitVec(lineHitVec), .regionHitVec(regionHitVec),
    .lineShr(lineShr), .regionShr(regionShr),
    .tgtTag(tgtTag), .tgtBlk(tgtBlk)
  );

  mgDirControl #(
    .NUM_WAYS(NUM_WAYS), .SHR_W(NUM_CORES), .TAG_W(TAG_W), .BLK_W(BLK_W)
  ) ctl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp), .reqShr(reqSharers),
    .validVec(validVec), .grainVec(grainVec),
    .lineHitVec(lineHitVec), .regionHitVec(regionHitVec),
    .lineShr(lineShr), .regionShr(regionShr),
    .tgtTag(tgtTag), .tgtBlk(tgtBlk),
    .strobe(strobe), .tgtWay(tgtWay),
    .rspValid(rspValid), .rspHit(rspHit), .rspLineGrain(rspLineGrain),
    .rspSharers(rspSharers), .evictValid(evictValid), .evictTag(evictTag),
    .evictBlk(evictBlk), .evictLineGrain(evictLineGrain)
  );

endmodule

// File: rtl/mgDirSet_chk.sv
module mgDirSet_chk #(
  parameter int NUM_WAYS = 8,
  parameter int SHR_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                reqValid,
  input logic [1:0]          reqOp,
  input logic                rspValid,
  input logic                rspHit,
  input logic                rspLineGrain,
  input logic [SHR_W-1:0]    rspSharers,
  input logic                evictValid,
  input logic [NUM_WAYS-1:0] validVec,
  input logic [NUM_WAYS-1:0] lineHitVec,
  input logic [NUM_WAYS-1:0] regionHitVec
);

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  p_miss_gives_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd0) |=> (rspHit || rspSharers == '0));

  p_line_grain_is_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd0) |=> (!rspLineGrain || rspHit));

  p_single_match_r10: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> ($countones(regionHitVec) <= 1 && $countones(lineHitVec) <= 1));

  p_evict_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !(&validVec)) |=> !evictValid);

  p_evict_only_alloc_r5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (reqOp == 2'd0 || reqOp == 2'd3)) |=> !evictValid);

  p_update_miss_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqOp == 2'd3 && lineHitVec == '0 && regionHitVec == '0)
      |=> $stable(validVec));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!rspValid && !evictValid && $stable(validVec)));

endmodule

bind mgDirSet mgDirSet_chk #(.NUM_WAYS(NUM_WAYS), .SHR_W(NUM_CORES)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
  .rspValid(rspValid), .rspHit(rspHit), .rspLineGrain(rspLineGrain),
  .rspSharers(rspSharers), .evictValid(evictValid), .validVec(validVec),
  .lineHitVec(lineHitVec), .regionHitVec(regionHitVec)
);

// File: tb/mgDirSet_tb_top.sv
`timescale 1ns/1ps
module mgDirSet_tb_top;

  localparam logic [1:0] LK = 2'd0, AR = 2'd1, AL = 2'd2, UP = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [15:0] shr;
    logic        eHit;
    logic        eLine;
    logic [15:0] eShr;
    logic        eEv;
    logic [14:0] eTag;
    logic [3:0]  eBlk;
    logic        eEvLine;
    logic [3:0]  req;
  } vec_t;

  // address = {tag[14:0], set[6:0], block[3:0], offset[5:0]}
  localparam int NVEC = 36;
  localparam vec_t VECS [NVEC] = '{
    '{LK, {15'd1,7'd0,4'd3,6'd0}, 16'h0000, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd1},  // R1 miss
    '{AR, {15'd1,7'd0,4'd0,6'd0}, 16'h000F, 1'b0,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd4},  // R4 way0
    '{LK, {15'd1,7'd0,4'd5,6'd0}, 16'h0000, 1'b1,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd2},  // R2 region
    '{AL, {15'd1,7'd0,4'd5,6'd0}, 16'h0030, 1'b0,1'b1,16'h0030, 1'b0,15'd0,4'd0,1'b0, 4'd4},  // R4 way1
    '{LK, {15'd1,7'd0,4'd5,6'd0}, 16'h0000, 1'b1,1'b1,16'h0030, 1'b0,15'd0,4'd0,1'b0, 4'd3},  // R3 override
    '{LK, {15'd1,7'd0,4'd6,6'd0}, 16'h0000, 1'b1,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd2},  // R2 other block
    '{AL, {15'd1,7'd0,4'd6,6'd0}, 16'h000F, 1'b0,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd11}, // R11 no entry
    '{LK, {15'd1,7'd0,4'd6,6'd0}, 16'h0000, 1'b1,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd11},
    '{UP, {15'd1,7'd0,4'd5,6'd0}, 16'h0070, 1'b1,1'b1,16'h0070, 1'b0,15'd0,4'd0,1'b0, 4'd7},  // R7 line
    '{LK, {15'd1,7'd0,4'd5,6'd0}, 16'h0000, 1'b1,1'b1,16'h0070, 1'b0,15'd0,4'd0,1'b0, 4'd7},
    '{UP, {15'd1,7'd0,4'd5,6'd0}, 16'h000F, 1'b1,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd8},  // R8 free
    '{LK, {15'd1,7'd0,4'd5,6'd0}, 16'h0000, 1'b1,1'b0,16'h000F, 1'b0,15'd0,4'd0,1'b0, 4'd8},
    '{UP, {15'd2,7'd0,4'd0,6'd0}, 16'h0001, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd9},  // R9 miss
    '{LK, {15'd2,7'd0,4'd0,6'd0}, 16'h0000, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd9},
    '{AR, {15'd1,7'd0,4'd0,6'd0}, 16'h00FF, 1'b1,1'b0,16'h00FF, 1'b0,15'd0,4'd0,1'b0, 4'd10}, // R10 in place
    '{UP, {15'd1,7'd0,4'd2,6'd0}, 16'h0100, 1'b1,1'b0,16'h0100, 1'b0,15'd0,4'd0,1'b0, 4'd7},  // R7 region
    '{LK, {15'd1,7'd0,4'd9,6'd0}, 16'h0000, 1'b1,1'b0,16'h0100, 1'b0,15'd0,4'd0,1'b0, 4'd7},
    '{AL, {15'd1,7'd0,4'd1,6'd0}, 16'h0001, 1'b0,1'b1,16'h0001, 1'b0,15'd0,4'd0,1'b0, 4'd8},  // R8 reuses freed way1
    '{AL, {15'd1,7'd0,4'd2,6'd0}, 16'h0002, 1'b0,1'b1,16'h0002, 1'b0,15'd0,4'd0,1'b0, 4'd4},
    '{AR, {15'd2,7'd0,4'd0,6'd0}, 16'h0200, 1'b0,1'b0,16'h0200, 1'b0,15'd0,4'd0,1'b0, 4'd4},
    '{AR, {15'd3,7'd0,4'd0,6'd0}, 16'h0300, 1'b0,1'b0,16'h0300, 1'b0,15'd0,4'd0,1'b0, 4'd4},
    '{AR, {15'd4,7'd0,4'd0,6'd0}, 16'h0400, 1'b0,1'b0,16'h0400, 1'b0,15'd0,4'd0,1'b0, 4'd4},
    '{AL, {15'd2,7'd0,4'd7,6'd0}, 16'h0800, 1'b0,1'b1,16'h0800, 1'b0,15'd0,4'd0,1'b0, 4'd4},
    '{AR, {15'd5,7'd0,4'd0,6'd0}, 16'h0500, 1'b0,1'b0,16'h0500, 1'b0,15'd0,4'd0,1'b0, 4'd4},  // set full
    '{AR, {15'd6,7'd0,4'd0,6'd0}, 16'h0600, 1'b0,1'b0,16'h0600, 1'b1,15'd1,4'd0,1'b0, 4'd5},  // R5 evict way0
    '{LK, {15'd1,7'd0,4'd1,6'd0}, 16'h0000, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd6},  // R6 line gone
    '{LK, {15'd6,7'd0,4'd3,6'd0}, 16'h0000, 1'b1,1'b0,16'h0600, 1'b0,15'd0,4'd0,1'b0, 4'd2},
    '{AL, {15'd6,7'd0,4'd3,6'd0}, 16'h0003, 1'b0,1'b1,16'h0003, 1'b0,15'd0,4'd0,1'b0, 4'd6},  // R6 freed way1
    '{AL, {15'd6,7'd0,4'd4,6'd0}, 16'h0004, 1'b0,1'b1,16'h0004, 1'b0,15'd0,4'd0,1'b0, 4'd6},  // R6 freed way2
    '{AL, {15'd3,7'd0,4'd1,6'd0}, 16'h0001, 1'b0,1'b1,16'h0001, 1'b1,15'd6,4'd3,1'b1, 4'd5},  // R5 way1 line
    '{LK, {15'd6,7'd0,4'd3,6'd0}, 16'h0000, 1'b1,1'b0,16'h0600, 1'b0,15'd0,4'd0,1'b0, 4'd5},
    '{AL, {15'd4,7'd0,4'd2,6'd0}, 16'h0002, 1'b0,1'b1,16'h0002, 1'b1,15'd6,4'd4,1'b1, 4'd5},  // R5 way2
    '{AR, {15'd7,7'd0,4'd0,6'd0}, 16'h0700, 1'b0,1'b0,16'h0700, 1'b1,15'd2,4'd0,1'b0, 4'd6},  // R6 region B
    '{LK, {15'd2,7'd0,4'd7,6'd0}, 16'h0000, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd6},
    '{LK, {15'd3,7'd0,4'd1,6'd0}, 16'h0000, 1'b1,1'b1,16'h0001, 1'b0,15'd0,4'd0,1'b0, 4'd3},
    '{LK, {15'd3,7'd0,4'd8,6'd0}, 16'h0000, 1'b1,1'b0,16'h0300, 1'b0,15'd0,4'd0,1'b0, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqSharers = '0;
  logic        rspValid, rspHit, rspLineGrain, evictValid, evictLineGrain;
  logic [15:0] rspSharers;
  logic [14:0] evictTag;
  logic [3:0]  evictBlk;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mgDirSet dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqSharers(reqSharers),
    .rspValid(rspValid), .rspHit(rspHit), .rspLineGrain(rspLineGrain),
    .rspSharers(rspSharers), .evictValid(evictValid), .evictTag(evictTag),
    .evictBlk(evictBlk), .evictLineGrain(evictLineGrain)
  );

  task automatic checkRsp(input string tag, input vec_t v);
    logic [39:0] act, exp;
    applied++;
    act = {rspValid, rspHit, rspLineGrain, rspSharers, evictValid,
           evictValid ? {evictTag, evictBlk, evictLineGrain} : 20'd0};
    exp = {1'b1, v.eHit, v.eLine, v.eShr, v.eEv,
           v.eEv ? {v.eTag, v.eBlk, v.eEvLine} : 20'd0};
    if (act[39:0] !== exp[39:0]) begin
      miscompares++;
      $display("FAIL %s R%0d: got v=%b hit=%b line=%b shr=%h ev=%b tag=%0d blk=%0d evl=%b, expected hit=%b line=%b shr=%h ev=%b tag=%0d blk=%0d evl=%b",
               tag, v.req, rspValid, rspHit, rspLineGrain, rspSharers, evictValid,
               evictTag, evictBlk, evictLineGrain, v.eHit, v.eLine, v.eShr, v.eEv,
               v.eTag, v.eBlk, v.eEvLine);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    reqValid   = 1'b1;
    reqOp      = v.op;
    reqAddr    = v.addr;
    reqSharers = v.shr;
    @(negedge clk);
    reqValid   = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    vec_t probe;
    repeat (3) @(negedge clk);
    // R12: reset state
    checkBit("R12 rspValid in reset", rspValid, 1'b0);
    checkBit("R12 evictValid in reset", evictValid, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      issue(VECS[i]);
      checkRsp($sformatf("vec%0d", i), VECS[i]);
    end

    // R13: idle cycle carrying an allocation is ignored
    reqValid = 1'b0; reqOp = AR; reqAddr = {15'd9, 7'd0, 4'd0, 6'd0}; reqSharers = 16'hFFFF;
    @(negedge clk);
    checkBit("R13 rspValid idle", rspValid, 1'b0);
    checkBit("R13 evictValid idle", evictValid, 1'b0);
    probe = '{LK, {15'd9,7'd0,4'd0,6'd0}, 16'h0000, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd13};
    issue(probe);
    checkRsp("R13 no allocation", probe);

    // R12: reset mid-run empties the set and rewinds the pointer
    rst = 1'b1;
    @(negedge clk);
    checkBit("R12 rspValid after reset", rspValid, 1'b0);
    rst = 1'b0;
    probe = '{LK, {15'd7,7'd0,4'd0,6'd0}, 16'h0000, 1'b0,1'b0,16'h0000, 1'b0,15'd0,4'd0,1'b0, 4'd12};
    issue(probe);
    checkRsp("R12 set emptied", probe);
    probe = '{AR, {15'd8,7'd0,4'd0,6'd0}, 16'h0008, 1'b0,1'b0,16'h0008, 1'b0,15'd0,4'd0,1'b0, 4'd12};
    issue(probe);
    checkRsp("R12 alloc after reset", probe);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule